// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two small unsigned operands one multiplier bit at a time. It is organised as a dedicated processor. A datapath holds three registers: a widened multiplicand that shifts left, a multiplier that shifts right, and a product accumulator. A ripple adder built from one-bit full adders forms each partial sum. A finite-state control unit drives the datapath's load, add and shift strobes and counts the steps.

A user places the operands on the inputs and raises `start` while the block is idle or finished. The operands must be valid on the clock edge that follows the accepting edge. After a fixed number of cycles, `done` rises and `product` holds the full-width result. Both stay put until the next accepted start. A start raised during a computation is ignored.

The reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two rising edges after `rst_n` goes high.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is applied, and after it is released, `product` reads 0 and `done` reads 0 until a start is accepted.
- R2: `start` is accepted only on a rising edge at which the control unit is idle or finished. In the cycle after the accepting edge, `done` reads 0.
- R3: The operands are sampled on the rising edge that follows the accepting edge. On that same edge the accumulator clears to 0. Operand values present at the accepting edge have no effect.
- R4: The product is built in four add steps, with bit i of the multiplier handled in step i, starting at bit 0. On the first edge of step i, the accumulator adds the multiplicand shifted left by i positions if bit i of the multiplier is 1, and is otherwise unchanged. On the second edge of the step, the registers shift. The adder never produces a carry out of the 8-bit result.
- R5: `done` rises on the tenth rising edge, counting the accepting edge as the first. At that point `product` equals the 8-bit unsigned product of the sampled operands.
- R6: Once `done` is high, `done` and `product` stay unchanged until a start is accepted, even if the operand inputs change.
- R7: A `start` raised while a computation is in progress is ignored. The running computation finishes with its original operands and its original timing.
- R8: A zero operand on either side gives a product of 0, and 15 x 15 gives 225.
- R9: A start accepted in the finished state begins a new computation at once. This lets back-to-back multiplications run with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| product | output | 8 | Accumulator contents; the full product once `done` is high |
| done | output | 1 | High from the end of a computation until the next accepted start |

## Verification
Some properties are checked on every cycle by the assertions:
- the accumulator clears on every load,
- the accumulator holds when it is neither loaded nor added to,
- no add ever carries out of the top bit,
- `done` stays high until a start arrives,
- a start during a computation never reloads the datapath,
- `done` rises only after the last step count.

Other behaviour can only be shown by the bench's scenarios, which compare a behavioural step model against the ports on every cycle. These scenarios cover:
- the exact value of each partial sum,
- the ten-edge latency,
- the sampling edge of the operands,
- correct products over all 256 operand pairs,
- the zero and all-ones corners,
- start pulses injected in mid-computation,
- back-to-back runs.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_TEST  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } mul_state_e;

  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } mul_ctl_t;

endpackage

// File: rtl/mul_full_adder.sv
module mul_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);

  always_comb begin
    s    = x ^ y ^ cin;
    cout = (x & y) | (cin & (x ^ y));
  end

endmodule

// File: rtl/mul_ripple_adder.sv
module mul_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    mul_full_adder u_fa (
      .x    (a[i]),
      .y    (b[i]),
      .cin  (carry[i]),
      .s    (sum[i]),
      .cout (carry[i+1])
    );
  end

  assign cout = carry[W];

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int OPW = 4,
  parameter int PW  = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  mul_ctl_t       ctl,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic           mlr_lsb,
  output logic [PW-1:0]  acc
);

  localparam int EXT = PW - OPW;

  logic [PW-1:0]  mcd_q, mcd_d;
  logic [OPW-1:0] mlr_q, mlr_d;
  logic [PW-1:0]  acc_q, acc_d;
  logic [PW-1:0]  sum;
  logic           carry_out;
  logic           mcd_en, mlr_en, acc_en;

  mul_ripple_adder #(.W(PW)) u_add (
    .a    (acc_q),
    .b    (mcd_q),
    .cin  (1'b0),
    .sum  (sum),
    .cout (carry_out)
  );

  // next-state logic
  always_comb begin
    mcd_en = ctl.load | ctl.shift;
    mlr_en = ctl.load | ctl.shift;
    acc_en = ctl.load | ctl.add;
    if (ctl.load) begin
      mcd_d = {{EXT{1'b0}}, op_a};
      mlr_d = op_b;
      acc_d = '0;
    end else begin
      mcd_d = mcd_q << 1;
      mlr_d = mlr_q >> 1;
      acc_d = sum;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcd_q <= '0;
      mlr_q <= '0;
      acc_q <= '0;
    end else begin
      if (mcd_en) mcd_q <= mcd_d;
      if (mlr_en) mlr_q <= mlr_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign mlr_lsb = mlr_q[0];
  assign acc     = acc_q;

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (acc_q == '0)); // R3

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.add) |=> $stable(acc_q)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.add |-> !carry_out); // R4

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int OPW = 4,
  parameter int CW  = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     mlr_lsb,
  output mul_ctl_t ctl,
  output logic     done
);

  localparam logic [CW-1:0] LAST = CW'(OPW - 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] step_q, step_d;
  logic          step_en;
  logic          busy;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_TEST;
      ST_TEST:  state_d = ST_SHIFT;
      ST_SHIFT: state_d = (step_q == LAST) ? ST_DONE : ST_TEST;
      ST_DONE:  if (start) state_d = ST_LOAD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step_en = (state_q == ST_LOAD) | (state_q == ST_SHIFT);
    step_d  = (state_q == ST_LOAD) ? '0 : step_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
    end
  end

  // outputs
  always_comb begin
    ctl.load  = (state_q == ST_LOAD);
    ctl.add   = (state_q == ST_TEST) & mlr_lsb;
    ctl.shift = (state_q == ST_SHIFT);
    done      = (state_q == ST_DONE);
    busy      = (state_q == ST_LOAD) | (state_q == ST_TEST) | (state_q == ST_SHIFT);
  end

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !ctl.load); // R7

  AST_DONE_AFTER_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(step_q) == LAST)); // R5

  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done); // R2

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int OPW = 4,
  parameter int PW  = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0]  product,
  output logic           done
);

  import mul_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  mul_ctl_t   ctl;
  logic       mlr_lsb;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_i = rst_sync_q[1];

  mul_ctrl #(.OPW(OPW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (start),
    .mlr_lsb (mlr_lsb),
    .ctl     (ctl),
    .done    (done)
  );

  mul_datapath #(.OPW(OPW), .PW(PW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_i),
    .ctl     (ctl),
    .op_a    (op_a),
    .op_b    (op_b),
    .mlr_lsb (mlr_lsb),
    .acc     (product)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_i |=> (!done && product == '0)); // R1

endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] op_a, op_b;
  logic [7:0] product;
  logic       done;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R1";
  bit    cmp_on = 1'b0;

  // behavioural model state
  int         t = -1;
  logic [3:0] ma = '0, mb = '0;
  logic [7:0] ep = '0;
  logic       ed = 1'b0;

  always #4 clk = ~clk;

  shift_add_mul i_shift_add_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product),
    .done    (done)
  );

  function automatic logic [7:0] partial(input logic [3:0] a, input logic [3:0] b, input int n);
    int s = 0;
    for (int j = 0; j < n; j++)
      if (b[j]) s += int'(a) << j;
    return 8'(s);
  endfunction

  // model: t counts edges since the accepting edge; 9 means finished
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = -1; ep = '0; ed = 1'b0;
    end else if (t == -1 || t == 9) begin
      if (start) begin t = 0; ed = 1'b0; end
    end else begin
      if (t == 0) begin ma = op_a; mb = op_b; end
      t  = t + 1;
      ep = partial(ma, mb, t / 2);
      ed = (t == 9);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check({tag, "/R4 product"}, product, ep);
      check({tag, "/R5 done"}, {7'd0, done}, {7'd0, ed});
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // start at a negedge with scrambled operands, real operands one cycle later (R3)
  task automatic run(input logic [3:0] a, input logic [3:0] b, input string req);
    int lat = 0;
    tag = req;
    op_a = ~a; op_b = b ^ 4'b1010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, "/R2 done low after accept"}, {7'd0, done}, 8'd0);
    op_a = a; op_b = b;
    lat = 1;
    while (!done && lat < 30) begin @(negedge clk); lat++; end
    check({req, "/R5 latency"}, 8'(lat), 8'd10);
    check({req, "/R5 result"}, product, 8'(int'(a) * int'(b)));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R1 reset product", product, 8'd0);
    check("R1 reset done", {7'd0, done}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    check("R1 after release", {done, product[6:0]}, 8'd0);

    run(4'd5, 4'd3, "R4");
    run(4'd9, 4'd6, "R4");
    run(4'd0, 4'd9, "R8");
    run(4'd11, 4'd0, "R8");
    run(4'd15, 4'd15, "R8");
    check("R8 15x15", product, 8'd225);

    // hold after done with changing operands
    tag = "R6";
    for (int k = 0; k < 8; k++) begin
      op_a = 4'(k * 3); op_b = 4'(k + 5);
      @(negedge clk);
      check("R6 product held", product, 8'd225);
      check("R6 done held", {7'd0, done}, 8'd1);
    end

    // start pulses while busy
    tag = "R7";
    op_a = 4'd7; op_b = 4'd13; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    op_a = 4'd2; op_b = 4'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check("R7 busy start ignored", product, 8'd91);

    // back-to-back: start raised in the first done cycle
    tag = "R9";
    run(4'd12, 4'd10, "R9");
    check("R9 first", product, 8'd120);
    run(4'd3, 4'd14, "R9");
    check("R9 second", product, 8'd42);

    // exhaustive sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(4'(a), 4'(b), "R4");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule